// File: doc/BRIEF.md
# Prioritized Interrupt Identifier Unit

This block keeps one interrupt-pending flag for each of a set of message objects (32 by default) and one flag for a status cause. A message handler raises an object's flag with a one-cycle set pulse. The CPU lowers it with a per-object clear request. A status-change event raises the status flag, and a read strobe on the status register lowers it.

From these flags the block presents a 16-bit identifier of the most urgent pending cause. The identifier is chosen by fixed rank and not by arrival order. It also drives one interrupt line toward the CPU, gated by a global enable bit.

The identifier follows the registered flags combinationally. A set, clear or read that is sampled at a clock edge is reflected in the identifier and the line straight after that edge. The enable bit acts on the line without any register delay.

Top module: `irq_id_unit`

## Requirements
- R1: When several causes are pending, the identifier names the highest-ranked one, whatever order they were raised in.
- R2: A pending status cause yields identifier 0x8000 and outranks every message object.
- R3: Bit i of `msg_set_i` and `msg_clr_i` belongs to object i+1. With no status cause pending, the identifier equals the number (1..NUM_OBJ) of the lowest-numbered pending object, so object 1 outranks object 2.
- R4: A message cause stays pending until its own clear bit is sampled. A clear aimed at any other object leaves it pending.
- R5: The status cause stays pending until `stat_rd_i` is sampled high.
- R6: `irq_o` is high exactly when `ie_i` is high and the identifier is nonzero, and it follows `ie_i` in the same cycle.
- R7: The identifier is 0x0000 when nothing is pending, and it never takes a value from 0x8001 to 0xFFFF or a message number above NUM_OBJ.
- R8: A set, clear or read sampled at a clock edge changes the identifier right after that edge, so a cleared cause exposes the next-ranked one one cycle after the clear is driven.
- R9: When a set and a clear for the same source (an object, or the status cause with its read strobe) are sampled in the same cycle, the source ends up pending.
- R10: A synchronous reset clears every flag, giving identifier 0x0000 and `irq_o` low on the cycle after reset is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| msg_set_i | input | NUM_OBJ | Per-object pending-set pulses from the message handler |
| msg_clr_i | input | NUM_OBJ | Per-object clear requests from the CPU |
| stat_evt_i | input | 1 | Status-change event, raises the status cause |
| stat_rd_i | input | 1 | Status-register read strobe, clears the status cause |
| ie_i | input | 1 | Global interrupt enable |
| int_id_o | output | 16 | Identifier of the highest-ranked pending cause |
| irq_o | output | 1 | Interrupt line to the CPU |

## Verification
Each set, clear or read strobe is driven on a falling edge and sampled on the next rising edge. The identifier must show the new flag state from that rising edge on, so the bench compares it on the following falling edge, one cycle after the stimulus is applied. The interrupt line depends on `ie_i` with no register, so a change of enable is visible in the same half-cycle in which it is driven. The bench's behavioural reference advances its flags on the same rising edge as the design and is compared every cycle. Directed checks at fixed points pin down the orderings, the same-cycle conflicts and reset.

// File: rtl/irq_id_pkg.sv
package irq_id_pkg;
    localparam int          ID_W      = 16;
    localparam logic [15:0] STAT_CODE = 16'h8000;
    localparam logic [15:0] NONE_CODE = 16'h0000;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int NUM_OBJ = 32
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [NUM_OBJ-1:0] set_i,
    input  logic [NUM_OBJ-1:0] clr_i,
    input  logic               stat_set_i,
    input  logic               stat_clr_i,
    output logic [NUM_OBJ-1:0] pend_o,
    output logic               stat_pend_o
);
    typedef struct packed {
        logic [NUM_OBJ-1:0] msg;
        logic               stat;
    } pend_t;

    pend_t st_d, st_q;

    // Set wins over a simultaneous clear so that no event is dropped.
    always_comb begin
        st_d      = st_q;
        st_d.msg  = set_i | (st_q.msg & ~clr_i);
        st_d.stat = stat_set_i | (st_q.stat & ~stat_clr_i);
        if (rst_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign pend_o      = st_q.msg;
    assign stat_pend_o = st_q.stat;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import irq_id_pkg::*;
#(
    parameter int NUM_OBJ = 32
) (
    input  logic [NUM_OBJ-1:0] pend_i,
    input  logic               stat_pend_i,
    output logic [ID_W-1:0]    id_o
);
    // Carry chain: above[g] is set when any object ranked above g is pending.
    logic [NUM_OBJ:0]   above;
    logic [NUM_OBJ-1:0] win;

    assign above[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < NUM_OBJ; g++) begin : g_rank
            assign win[g]     = pend_i[g] & ~above[g];
            assign above[g+1] = above[g] | pend_i[g];
        end
    endgenerate

    logic [ID_W-1:0] msg_code;

    always_comb begin
        msg_code = NONE_CODE;
        for (int i = 0; i < NUM_OBJ; i++) begin
            if (win[i]) begin
                msg_code = msg_code | ID_W'(i + 1);
            end
        end
    end

    assign id_o = stat_pend_i ? STAT_CODE : msg_code;
endmodule

// File: rtl/irq_id_unit.sv
module irq_id_unit
    import irq_id_pkg::*;
#(
    parameter int NUM_OBJ = 32
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [NUM_OBJ-1:0] msg_set_i,
    input  logic [NUM_OBJ-1:0] msg_clr_i,
    input  logic               stat_evt_i,
    input  logic               stat_rd_i,
    input  logic               ie_i,
    output logic [15:0]        int_id_o,
    output logic               irq_o
);
    localparam int MAX_OBJ = 32767;

    generate
        if (NUM_OBJ < 1 || NUM_OBJ > MAX_OBJ) begin : g_bad_cfg
            $error("NUM_OBJ out of range");
        end
    endgenerate

    logic [NUM_OBJ-1:0] pend_msg;
    logic               pend_stat;
    logic [ID_W-1:0]    id_w;

    irq_pend_bank #(.NUM_OBJ(NUM_OBJ)) u_bank (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .set_i       (msg_set_i),
        .clr_i       (msg_clr_i),
        .stat_set_i  (stat_evt_i),
        .stat_clr_i  (stat_rd_i),
        .pend_o      (pend_msg),
        .stat_pend_o (pend_stat)
    );

    irq_prio_enc #(.NUM_OBJ(NUM_OBJ)) u_enc (
        .pend_i      (pend_msg),
        .stat_pend_i (pend_stat),
        .id_o        (id_w)
    );

    assign int_id_o = id_w;
    assign irq_o    = ie_i & (|id_w);
endmodule

// File: rtl/irq_id_unit_chk.sv
module irq_id_unit_chk #(
    parameter int NUM_OBJ = 32
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic [NUM_OBJ-1:0] msg_set_i,
    input logic               stat_evt_i,
    input logic               stat_rd_i,
    input logic               ie_i,
    input logic [NUM_OBJ-1:0] pend_msg,
    input logic               pend_stat,
    input logic [15:0]        int_id_o,
    input logic               irq_o
);
    AST_STAT_ON_TOP: assert property (@(posedge clk_i) disable iff (rst_i)
        pend_stat |-> (int_id_o == 16'h8000));                         // R2

    AST_OBJ1_FIRST: assert property (@(posedge clk_i) disable iff (rst_i)
        (pend_msg[0] && !pend_stat) |-> (int_id_o == 16'h0001));       // R3

    AST_STAT_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
        (pend_stat && !stat_rd_i) |=> pend_stat);                      // R5

    AST_LINE_UP: assert property (@(posedge clk_i) disable iff (rst_i)
        (ie_i && pend_stat) |-> irq_o);                                // R6

    AST_NO_RESERVED: assert property (@(posedge clk_i) disable iff (rst_i)
        (int_id_o == 16'h8000) || (int_id_o <= 16'(NUM_OBJ)));         // R7

    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
        (msg_set_i[0] || stat_evt_i) |=> (int_id_o != 16'h0000));      // R9

    AST_RESET_CLEAR: assert property (@(posedge clk_i)
        rst_i |=> (int_id_o == 16'h0000 && !irq_o));                   // R10
endmodule

bind irq_id_unit irq_id_unit_chk #(.NUM_OBJ(NUM_OBJ)) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .msg_set_i  (msg_set_i),
    .stat_evt_i (stat_evt_i),
    .stat_rd_i  (stat_rd_i),
    .ie_i       (ie_i),
    .pend_msg   (pend_msg),
    .pend_stat  (pend_stat),
    .int_id_o   (int_id_o),
    .irq_o      (irq_o)
);

// File: tb/irq_id_unit_bench.sv
`timescale 1ns/1ps
module irq_id_unit_bench;
    localparam int N = 32;

    logic         clk_i = 1'b0;
    logic         rst_i = 1'b1;
    logic [N-1:0] msg_set_i = '0;
    logic [N-1:0] msg_clr_i = '0;
    logic         stat_evt_i = 1'b0;
    logic         stat_rd_i = 1'b0;
    logic         ie_i = 1'b0;
    logic [15:0]  int_id_o;
    logic         irq_o;

    int    n_run  = 0;
    int    n_fail = 0;
    string tag    = "R10";

    // Behavioural reference
    bit    mdl_msg [N];
    bit    mdl_stat;

    always #2 clk_i = ~clk_i;

    irq_id_unit #(.NUM_OBJ(N)) u_irq_id_unit (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .msg_set_i  (msg_set_i),
        .msg_clr_i  (msg_clr_i),
        .stat_evt_i (stat_evt_i),
        .stat_rd_i  (stat_rd_i),
        .ie_i       (ie_i),
        .int_id_o   (int_id_o),
        .irq_o      (irq_o)
    );

    function automatic int mdl_id();
        if (mdl_stat) return 32'h8000;
        for (int k = 0; k < N; k++) if (mdl_msg[k]) return k + 1;
        return 0;
    endfunction

    task automatic check(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One clock: model follows the sampled inputs, compare on falling edge.
    task automatic cyc();
        int e;
        @(posedge clk_i);
        if (rst_i) begin
            for (int k = 0; k < N; k++) mdl_msg[k] = 1'b0;
            mdl_stat = 1'b0;
        end else begin
            for (int k = 0; k < N; k++)
                mdl_msg[k] = msg_set_i[k] || (mdl_msg[k] && !msg_clr_i[k]);
            mdl_stat = stat_evt_i || (mdl_stat && !stat_rd_i);
        end
        @(negedge clk_i);
        e = mdl_id();
        check({tag, " id"}, int'(int_id_o), e);
        check({tag, " irq"}, int'(irq_o), int'(ie_i && e != 0));
        check("R7 range", int'(int_id_o == 16'h8000 || int_id_o <= N), 1);
        msg_set_i  = '0;
        msg_clr_i  = '0;
        stat_evt_i = 1'b0;
        stat_rd_i  = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk_i);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        for (int k = 0; k < N; k++) mdl_msg[k] = 1'b0;
        mdl_stat = 1'b0;
        @(negedge clk_i);
        repeat (3) cyc();
        check("R10 reset id", int'(int_id_o), 0);
        check("R10 reset irq", int'(irq_o), 0);
        rst_i = 1'b0;
        ie_i  = 1'b1;

        tag = "R3"; msg_set_i[4] = 1'b1; cyc();
        check("R3 obj5", int'(int_id_o), 5);
        check("R8 line after set", int'(irq_o), 1);
        tag = "R1"; msg_set_i[1] = 1'b1; cyc();
        check("R1 later obj2 wins", int'(int_id_o), 2);
        tag = "R8"; msg_clr_i[1] = 1'b1; cyc();
        check("R8 next exposed", int'(int_id_o), 5);
        tag = "R4"; msg_clr_i[6] = 1'b1; cyc();
        check("R4 other clear", int'(int_id_o), 5);
        repeat (2) cyc();
        check("R4 held", int'(int_id_o), 5);

        tag = "R2"; stat_evt_i = 1'b1; cyc();
        check("R2 status", int'(int_id_o), 32'h8000);
        tag = "R5"; repeat (3) cyc();
        check("R5 status held", int'(int_id_o), 32'h8000);
        stat_rd_i = 1'b1; cyc();
        check("R5 read clears", int'(int_id_o), 5);

        tag = "R6"; ie_i = 1'b0; #0.5;
        check("R6 ie low", int'(irq_o), 0);
        cyc();
        ie_i = 1'b1; #0.5;
        check("R6 ie high", int'(irq_o), 1);
        cyc();

        tag = "R9"; msg_set_i[2] = 1'b1; msg_clr_i[2] = 1'b1; cyc();
        check("R9 msg set wins", int'(int_id_o), 3);
        stat_evt_i = 1'b1; stat_rd_i = 1'b1; cyc();
        check("R9 stat set wins", int'(int_id_o), 32'h8000);
        stat_rd_i = 1'b1; cyc();
        check("R9 stat then read", int'(int_id_o), 3);

        tag = "R3"; msg_set_i = '1; cyc();
        check("R3 all pending", int'(int_id_o), 1);
        for (int k = 0; k < N; k++) begin
            msg_clr_i[k] = 1'b1; cyc();
            check("R3 walk", int'(int_id_o), (k == N - 1) ? 0 : k + 2);
        end
        check("R7 none", int'(int_id_o), 0);
        check("R6 none line", int'(irq_o), 0);

        tag = "R10"; msg_set_i[N-1] = 1'b1; stat_evt_i = 1'b1; cyc();
        rst_i = 1'b1; msg_set_i[3] = 1'b1; cyc();
        check("R10 reset clears", int'(int_id_o), 0);
        rst_i = 1'b0; cyc();
        check("R10 stays clear", int'(int_id_o), 0);

        tag = "R1"; lfsr = 32'h1ACE_B00C;
        for (int t = 0; t < 400; t++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            msg_set_i  = (lfsr[3:0] == 4'h0) ? (32'h1 << lfsr[8:4]) : '0;
            msg_clr_i  = (lfsr[12:10] == 3'h0) ? (32'h1 << lfsr[20:16]) : '0;
            stat_evt_i = (lfsr[27:24] == 4'h5);
            stat_rd_i  = (lfsr[30:28] == 3'h2);
            ie_i       = lfsr[22] | lfsr[9];
            cyc();
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule